// File: doc/BRIEF.md
# Peripheral Control Line Unit

This block serves two pairs of control lines on a peripheral interface. Each pair has one input-only sense line and one line that can be driven. Software writes a single 8-bit control word, and the word holds one 4-bit field per pair. Inside a field, one bit chooses whether the sense line reacts to rising or to falling transitions. The other three bits choose whether the drive line is held low, held high, or left undriven.

Each sense line passes through a two-flop synchroniser and then an edge detector. When the detector sees a transition of the chosen polarity, it emits a one-cycle set pulse at a fixed bit position of an 8-bit interrupt-flag set vector. A separate interrupt controller stores the flags; this block does not. The drive lines appear as a level plus an output enable. The output enable is low whenever the field does not request a static level.

Top module: `ctl_line_unit`

## Requirements
- R1: After reset the control word is zero: both drive lines have output enable 0 and level 0, and the flag set vector is zero.
- R2: With control bit 0 at 0, a high-to-low transition on `sense_a` raises `flag_set[1]` for exactly one cycle. The pulse is seen after the second rising clock edge that follows the pin change.
- R3: With control bit 0 at 1, a low-to-high transition on `sense_a` raises `flag_set[1]` with the same one-cycle timing.
- R4: A transition on a sense line whose direction is opposite to the selected polarity produces no flag pulse.
- R5: Control bit 4 selects the `sense_b` polarity (0 falling, 1 rising), and a matching transition pulses `flag_set[4]` with the R2 timing.
- R6: Control bits 3:1 set the `drv_a` mode. Code 3'b110 gives output enable 1 with level 0, and code 3'b111 gives output enable 1 with level 1. The change is visible in the cycle after the write edge.
- R7: Control bits 7:5 set the `drv_b` mode with the same codes and timing as R6.
- R8: Any drive code other than 3'b110 or 3'b111 gives output enable 0 and level 0.
- R9: Bits 0, 2, 3, 5, 6 and 7 of `flag_set` are always 0, and each pair pulses only its own bit.
- R10: Writing the control word, including a change of polarity, produces no flag pulse while the sense lines are stable.
- R11: A single qualifying transition yields exactly one pulse cycle, even when the line then stays at its new level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word write data |
| sense_a | input | 1 | Sense line of pair A (asynchronous) |
| sense_b | input | 1 | Sense line of pair B (asynchronous) |
| drv_a | output | 1 | Drive level of pair A |
| drv_a_oe | output | 1 | Output enable of pair A |
| drv_b | output | 1 | Drive level of pair B |
| drv_b_oe | output | 1 | Output enable of pair B |
| flag_set | output | 8 | One-cycle interrupt flag set pulses (bit 1 pair A, bit 4 pair B) |

## Verification
Each sense line is driven in both directions under both polarity settings. This separates a correct polarity decode from an inverted one or a mere any-change detector. Both sense lines are then moved in the same cycle in the same direction while the two pairs are set to opposite polarities. That pattern catches swapped pair fields or swapped flag positions. The drive field is stepped through all eight codes on both pairs at once, which tells the two static codes apart from each other and from the undriven ones. Control writes made while the lines are held still show whether a polarity change alone can fake an edge.

// File: rtl/ctl_line_pkg.sv
package ctl_line_pkg;

    localparam int unsigned NUM_PAIRS   = 2;
    localparam int unsigned MODE_W      = 3;
    localparam int unsigned FIELD_W     = MODE_W + 1;
    localparam int unsigned CTL_W       = NUM_PAIRS * FIELD_W;
    localparam int unsigned FLAG_W      = 8;
    localparam int unsigned SYNC_STAGES = 2;

    // static drive codes of a pair's mode field
    localparam logic [MODE_W-1:0] MODE_HOLD_LOW  = 3'b110;
    localparam logic [MODE_W-1:0] MODE_HOLD_HIGH = 3'b111;

    // flag bit pulsed by each pair: pair 0 -> bit 1, pair 1 -> bit 4
    localparam int unsigned FLAG_POS [NUM_PAIRS] = '{1, 4};

    // one field per pair: mode in the upper bits, polarity in the lowest bit
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              rise_sel;
    } pair_cfg_t;

    typedef pair_cfg_t [NUM_PAIRS-1:0] ctl_word_t;

    typedef struct packed {
        ctl_word_t ctl;
    } unit_state_t;

endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/ctl_edge_det.sv
module ctl_edge_det #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic rise_sel,
    output logic hit
);

    logic prev_d;
    logic prev_q;

    always_comb begin
        prev_d = level;
        if (rise_sel) begin
            hit = level & ~prev_q;
        end else begin
            hit = ~level & prev_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= RST_VAL;
        end else begin
            prev_q <= prev_d;
        end
    end

endmodule

// File: rtl/ctl_drive_dec.sv
module ctl_drive_dec
    import ctl_line_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output logic              level,
    output logic              oe
);

    always_comb begin
        level = 1'b0;
        oe    = 1'b0;
        unique case (mode)
            MODE_HOLD_LOW: begin
                oe    = 1'b1;
                level = 1'b0;
            end
            MODE_HOLD_HIGH: begin
                oe    = 1'b1;
                level = 1'b1;
            end
            default: begin
                oe    = 1'b0;
                level = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ctl_line_unit.sv
module ctl_line_unit
    import ctl_line_pkg::*;
#(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CTL_W-1:0] cfg_wdata,
    input  logic             sense_a,
    input  logic             sense_b,
    output logic             drv_a,
    output logic             drv_a_oe,
    output logic             drv_b,
    output logic             drv_b_oe,
    output logic [FLAG_W-1:0] flag_set
);

    unit_state_t st_d;
    unit_state_t st_q;

    logic [NUM_PAIRS-1:0] sense_v;
    logic [NUM_PAIRS-1:0] synced_v;
    logic [NUM_PAIRS-1:0] hit_v;
    logic [NUM_PAIRS-1:0] lvl_v;
    logic [NUM_PAIRS-1:0] oe_v;

    assign sense_v = {sense_b, sense_a};

    // control word register
    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            st_d.ctl = ctl_word_t'(cfg_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // per-pair datapath
    for (genvar gi = 0; gi < NUM_PAIRS; gi++) begin : g_pair
        ctl_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (IDLE_LEVEL)
        ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (sense_v[gi]),
            .dout  (synced_v[gi])
        );

        ctl_edge_det #(
            .RST_VAL (IDLE_LEVEL)
        ) u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .level    (synced_v[gi]),
            .rise_sel (st_q.ctl[gi].rise_sel),
            .hit      (hit_v[gi])
        );

        ctl_drive_dec u_dec (
            .mode  (st_q.ctl[gi].mode),
            .level (lvl_v[gi]),
            .oe    (oe_v[gi])
        );
    end

    always_comb begin
        flag_set = '0;
        for (int i = 0; i < NUM_PAIRS; i++) begin
            flag_set[FLAG_POS[i]] = hit_v[i];
        end
    end

    assign drv_a    = lvl_v[0];
    assign drv_a_oe = oe_v[0];
    assign drv_b    = lvl_v[1];
    assign drv_b_oe = oe_v[1];

endmodule

// File: rtl/ctl_line_unit_chk.sv
module ctl_line_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic       drv_a,
    input logic       drv_a_oe,
    input logic       drv_b,
    input logic       drv_b_oe,
    input logic [7:0] flag_set
);

    a_r9_unused_flags_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_set & 8'hED) == 8'h00);

    a_r11_single_pulse_a: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_set[1] && !cfg_we) |=> !flag_set[1]);

    a_r11_single_pulse_b: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_set[4] && !cfg_we) |=> !flag_set[4]);

    a_r6_drive_a_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(drv_a) && $stable(drv_a_oe)));

    a_r7_drive_b_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(drv_b) && $stable(drv_b_oe)));

    a_r8_idle_level_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!drv_a_oe || !drv_b_oe) |-> ((drv_a_oe || !drv_a) && (drv_b_oe || !drv_b)));

endmodule

bind ctl_line_unit ctl_line_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .drv_a    (drv_a),
    .drv_a_oe (drv_a_oe),
    .drv_b    (drv_b),
    .drv_b_oe (drv_b_oe),
    .flag_set (flag_set)
);

// File: tb/ctl_line_unit_bench.sv
`timescale 1ns/1ps
module ctl_line_unit_bench;

    typedef struct {
        logic [7:0] flags;
        logic       da;
        logic       dao;
        logic       db;
        logic       dbo;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       sense_a = 1'b1;
    logic       sense_b = 1'b1;
    logic       drv_a, drv_a_oe, drv_b, drv_b_oe;
    logic [7:0] flag_set;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t q[$];
    logic [7:0] model_ctl = 8'h00;

    always #5 clk = ~clk;

    ctl_line_unit u_ctl_line_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .sense_a   (sense_a),
        .sense_b   (sense_b),
        .drv_a     (drv_a),
        .drv_a_oe  (drv_a_oe),
        .drv_b     (drv_b),
        .drv_b_oe  (drv_b_oe),
        .flag_set  (flag_set)
    );

    // drive model per requirement: 110 low, 111 high, else undriven
    function automatic logic [1:0] drive_of(input logic [2:0] code);
        if (code == 3'b110) return 2'b10;
        if (code == 3'b111) return 2'b11;
        return 2'b00;
    endfunction

    // driver: one cycle of stimulus, expected outputs after the next posedge
    task automatic tick(input logic we, input logic [7:0] wd, input logic sa,
                        input logic sb, input logic [7:0] exp_flags, input string req);
        exp_t e;
        logic [1:0] a_d;
        logic [1:0] b_d;
        cfg_we    = we;
        cfg_wdata = wd;
        sense_a   = sa;
        sense_b   = sb;
        if (we) model_ctl = wd;
        a_d = drive_of(model_ctl[3:1]);
        b_d = drive_of(model_ctl[7:5]);
        e.flags = exp_flags;
        e.dao = a_d[1];
        e.da  = a_d[0];
        e.dbo = b_d[1];
        e.db  = b_d[0];
        e.req = req;
        q.push_back(e);
        @(negedge clk);
    endtask

    // monitor: compares a couple of ns after each posedge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (flag_set !== e.flags || drv_a !== e.da || drv_a_oe !== e.dao ||
                    drv_b !== e.db || drv_b_oe !== e.dbo) begin
                    errors++;
                    $display("FAIL %s: got flags=%h a=%b/%b b=%b/%b expected flags=%h a=%b/%b b=%b/%b",
                             e.req, flag_set, drv_a, drv_a_oe, drv_b, drv_b_oe,
                             e.flags, e.da, e.dao, e.db, e.dbo);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got no completion expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        tick(0, 8'h00, 1, 1, 8'h00, "R1");
        tick(0, 8'h00, 1, 1, 8'h00, "R1");
        // R2 falling edge on sense_a, R11 single pulse
        tick(0, 8'h00, 0, 1, 8'h00, "R2");
        tick(0, 8'h00, 0, 1, 8'h02, "R2");
        tick(0, 8'h00, 0, 1, 8'h00, "R11");
        tick(0, 8'h00, 0, 1, 8'h00, "R11");
        // R4 rising edge while falling selected
        tick(0, 8'h00, 1, 1, 8'h00, "R4");
        tick(0, 8'h00, 1, 1, 8'h00, "R4");
        tick(0, 8'h00, 1, 1, 8'h00, "R4");
        // R10 polarity change with stable line
        tick(1, 8'h01, 1, 1, 8'h00, "R10");
        tick(0, 8'h01, 1, 1, 8'h00, "R10");
        tick(0, 8'h01, 1, 1, 8'h00, "R10");
        // R4 falling edge while rising selected
        tick(0, 8'h01, 0, 1, 8'h00, "R4");
        tick(0, 8'h01, 0, 1, 8'h00, "R4");
        tick(0, 8'h01, 0, 1, 8'h00, "R4");
        // R3 rising edge on sense_a
        tick(0, 8'h01, 1, 1, 8'h00, "R3");
        tick(0, 8'h01, 1, 1, 8'h02, "R3");
        tick(0, 8'h01, 1, 1, 8'h00, "R11");
        // R5 falling on sense_b with bit 4 clear
        tick(0, 8'h01, 1, 0, 8'h00, "R5");
        tick(0, 8'h01, 1, 0, 8'h10, "R5");
        tick(0, 8'h01, 1, 0, 8'h00, "R11");
        // R5 rising on sense_b with bit 4 set
        tick(1, 8'h11, 1, 0, 8'h00, "R10");
        tick(0, 8'h11, 1, 1, 8'h00, "R5");
        tick(0, 8'h11, 1, 1, 8'h10, "R5");
        tick(0, 8'h11, 1, 1, 8'h00, "R5");
        // R9 both lines fall together: pair A falling, pair B rising selected
        tick(1, 8'h10, 1, 1, 8'h00, "R10");
        tick(0, 8'h10, 0, 0, 8'h00, "R9");
        tick(0, 8'h10, 0, 0, 8'h02, "R9");
        tick(0, 8'h10, 0, 0, 8'h00, "R9");
        // R9 both lines rise together
        tick(0, 8'h10, 1, 1, 8'h00, "R9");
        tick(0, 8'h10, 1, 1, 8'h10, "R9");
        tick(0, 8'h10, 1, 1, 8'h00, "R9");
        // R6/R7 static drive codes
        tick(1, 8'h0C, 1, 1, 8'h00, "R6");
        tick(1, 8'h0E, 1, 1, 8'h00, "R6");
        tick(1, 8'hC0, 1, 1, 8'h00, "R7");
        tick(1, 8'hE0, 1, 1, 8'h00, "R7");
        tick(1, 8'hEC, 1, 1, 8'h00, "R7");
        tick(0, 8'hEC, 1, 1, 8'h00, "R6");
        // R8 every non-static code on both pairs
        for (int c = 0; c < 6; c++) begin
            logic [7:0] w;
            w = 8'((c << 1) | (c << 5));
            tick(1, w, 1, 1, 8'h00, "R8");
        end
        // R10 polarity toggles with stable lines
        tick(1, 8'h01, 1, 1, 8'h00, "R10");
        tick(1, 8'h10, 1, 1, 8'h00, "R10");
        tick(1, 8'h11, 1, 1, 8'h00, "R10");
        tick(0, 8'h11, 1, 1, 8'h00, "R10");
        tick(0, 8'h11, 1, 1, 8'h00, "R10");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule